// File: doc/BRIEF.md
# Filler-Stripping Three-Lane Character Decoder

This block sits behind the bit-level deserialisers of a serial video link. Each link clock enable it takes one aligned 10-bit character on each of three colour lanes (blue, green, red). When the link clock runs at two or four times the pixel rate, the stream is padded with filler characters at fixed slot positions. The block discards that padding and decodes the remaining characters. A data character becomes an 8-bit colour component. A control character on the blue lane carries horizontal and vertical sync, with data enable low.

Lane skew of a few characters is removed by a per-lane history buffer. During each blanking period the block watches where each lane leaves control characters and enters data. It picks the history tap for each lane so that those three boundaries line up. The first such alignment sets a lock flag. Every later blanking period repeats the measurement, so a change in skew is absorbed at the next line start. Pixels come out one per data slot with a one-cycle valid strobe, and only while locked.

Top module: `vlink_destuff`

## Requirements
- R1: While rst_n is low, every output (colour, sync, de, pix_vld, locked) reads 0.
- R2: ratio 0 selects 1x, 1 selects 2x, 2 or 3 selects 4x. In 2x and 4x the data slot is the first non-filler character after a control run, and each group of 2 or 4 slots holds one data slot followed by filler 0001111010. pix_vld pulses exactly once per data slot, so a line of N pixels yields N strobes in order.
- R3: A data character c decodes as q = c[9] ? ~c[7:0] : c[7:0]. Output bit 0 is q[0]. Output bit i is q[i]^q[i-1] when c[8]=1 and its complement when c[8]=0. The lanes map ch_b to blu, ch_g to grn and ch_r to red, with de=1.
- R4: A data slot whose blue character is a control code drives de=0 and all colour bits to 0. It sets {vsync,hsync} to 00 for 1101010100, 01 for 0010101011, 10 for 0101010100 and 11 for 1010101011. hsync and vsync change only on such a control pixel.
- R5: The three lanes may reach their control-to-data boundary within DEPTH-1 enabled cycles of each other. When they do, each lane is delayed so the boundaries coincide and locked is set. pix_vld is only ever high in a cycle after one in which locked was high.
- R6: Skew is re-measured at every control-to-data boundary. After the lane skews change, output from the following line onward is again correctly aligned.
- R7: A filler character on any lane in a data slot clears locked.
- R8: locked is cleared when the lanes' boundaries spread over more than DEPTH-1 enabled cycles.
- R9: With lane_en low, no state changes and pix_vld is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_en | input | 1 | One character per lane is present this cycle |
| ratio | input | 2 | Link-to-pixel ratio: 0 = 1x, 1 = 2x, 2/3 = 4x |
| ch_b | input | 10 | Blue lane character |
| ch_g | input | 10 | Green lane character |
| ch_r | input | 10 | Red lane character |
| red | output | 8 | Decoded red component |
| grn | output | 8 | Decoded green component |
| blu | output | 8 | Decoded blue component |
| hsync | output | 1 | Horizontal sync from the last control pixel |
| vsync | output | 1 | Vertical sync from the last control pixel |
| de | output | 1 | High for a data pixel, low for a control pixel |
| pix_vld | output | 1 | One-cycle strobe per recovered pixel |
| locked | output | 1 | Lanes aligned |

## Verification
The bench builds the block with DEPTH=4, which allows up to three cycles of lane-to-lane skew. Skew sets that use all of that window are driven, and one set spreads the lanes over six cycles to force the out-of-range unlock. All four ratio codes are run, two of them with random idle cycles on lane_en. Random choices of XOR/XNOR and inversion for each character reach every branch of the decode, and a per-line control code walks through all four sync combinations.

// File: rtl/vlink_destuff.sv
`timescale 1ns/1ps
module vlink_destuff #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lane_en,
  input  logic [1:0] ratio,
  input  logic [9:0] ch_b,
  input  logic [9:0] ch_g,
  input  logic [9:0] ch_r,
  output logic [7:0] red,
  output logic [7:0] grn,
  output logic [7:0] blu,
  output logic       hsync,
  output logic       vsync,
  output logic       de,
  output logic       pix_vld,
  output logic       locked
);
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [TW-1:0] LAST = TW'(DEPTH - 1);
  localparam logic [9:0] FILL = 10'b0001111010;

  function automatic logic is_ctl(input logic [9:0] c);
    return c == 10'h354 || c == 10'h0AB || c == 10'h154 || c == 10'h2AB;
  endfunction

  function automatic logic [1:0] ctl_code(input logic [9:0] c);
    case (c)
      10'h0AB: return 2'b01;
      10'h154: return 2'b10;
      10'h2AB: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [7:0] dec8(input logic [9:0] c);
    logic [7:0] q, o;
    q = c[9] ? ~c[7:0] : c[7:0];
    o[0] = q[0];
    for (int i = 1; i < 8; i++) o[i] = c[8] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
    return o;
  endfunction

  logic [9:0]    lin   [3];
  logic [9:0]    hist  [3][DEPTH];
  logic [9:0]    al    [3];
  logic [TW-1:0] sel   [3];
  logic [TW-1:0] stamp [3];
  logic [2:0]    last_ctl, seen, ev;
  logic [TW-1:0] wcnt, cur;
  logic [1:0]    phase, pmask;
  logic          win_open, win_done, win_fail;
  logic          al_last_ctl, al_bnd, slot_data, fill_hit;

  assign lin[0] = ch_b;
  assign lin[1] = ch_g;
  assign lin[2] = ch_r;

  always_comb begin
    for (int l = 0; l < 3; l++) begin
      ev[l] = last_ctl[l] && !is_ctl(lin[l]) && lin[l] != FILL;
      al[l] = hist[l][sel[l]];
    end
  end

  assign cur       = win_open ? wcnt : '0;
  assign win_done  = &(seen | ev);
  assign win_fail  = (win_open || |ev) && !win_done && cur == LAST;
  assign pmask     = (ratio == 2'd0) ? 2'd0 : (ratio == 2'd1) ? 2'd1 : 2'd3;
  assign al_bnd    = al_last_ctl && !is_ctl(al[0]) && al[0] != FILL;
  assign slot_data = al_bnd || phase == 2'd0;
  assign fill_hit  = slot_data && (al[0] == FILL || al[1] == FILL || al[2] == FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) begin
        for (int k = 0; k < DEPTH; k++) hist[l][k] <= '0;
        sel[l]   <= '0;
        stamp[l] <= '0;
      end
      last_ctl    <= '0;
      seen        <= '0;
      win_open    <= 1'b0;
      wcnt        <= '0;
      al_last_ctl <= 1'b0;
      phase       <= '0;
      locked      <= 1'b0;
      pix_vld     <= 1'b0;
      de          <= 1'b0;
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      red         <= '0;
      grn         <= '0;
      blu         <= '0;
    end else if (lane_en) begin
      for (int l = 0; l < 3; l++) begin
        hist[l][0] <= lin[l];
        for (int k = 1; k < DEPTH; k++) hist[l][k] <= hist[l][k-1];
        if (lin[l] != FILL) last_ctl[l] <= is_ctl(lin[l]);
        if (ev[l] && !seen[l]) stamp[l] <= cur;
        if (win_done) sel[l] <= cur - (seen[l] ? stamp[l] : cur);
      end
      if (win_done || win_fail) begin
        win_open <= 1'b0;
        seen     <= '0;
        wcnt     <= '0;
      end else if (win_open || |ev) begin
        win_open <= 1'b1;
        seen     <= seen | ev;
        wcnt     <= cur + 1'b1;
      end
      if (al[0] != FILL) al_last_ctl <= is_ctl(al[0]);
      phase <= (slot_data ? 2'd1 : phase + 2'd1) & pmask;
      if (win_done) locked <= 1'b1;
      else if (fill_hit || win_fail) locked <= 1'b0;
      pix_vld <= slot_data && locked;
      if (slot_data && locked) begin
        if (is_ctl(al[0])) begin
          de             <= 1'b0;
          {red, grn, blu} <= '0;
          {vsync, hsync} <= ctl_code(al[0]);
        end else begin
          de  <= 1'b1;
          blu <= dec8(al[0]);
          grn <= dec8(al[1]);
          red <= dec8(al[2]);
        end
      end
    end else begin
      pix_vld <= 1'b0;
    end
  end
endmodule

module vlink_destuff_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lane_en,
  input logic [7:0] red,
  input logic [7:0] grn,
  input logic [7:0] blu,
  input logic       hsync,
  input logic       vsync,
  input logic       de,
  input logic       pix_vld,
  input logic       locked
);
  p_strobe_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(lane_en));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> ($stable(locked) && !pix_vld));
  p_strobe_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $past(locked));
  p_blank_black_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !de) |-> (red == 8'd0 && grn == 8'd0 && blu == 8'd0));
  p_sync_on_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({hsync, vsync}) |-> (pix_vld && !de));
endmodule

bind vlink_destuff vlink_destuff_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .red(red), .grn(grn), .blu(blu),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_vld(pix_vld), .locked(locked)
);

// File: tb/test_vlink_destuff.sv
`timescale 1ns/1ps
module test_vlink_destuff;
  localparam int BLANK  = 16;
  localparam int ACTIVE = 24;
  localparam logic [9:0] FILL = 10'b0001111010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lane_en = 1'b0;
  logic [1:0] ratio = 2'd0;
  logic [9:0] ch_b = '0, ch_g = '0, ch_r = '0;
  logic [7:0] red, grn, blu;
  logic hsync, vsync, de, pix_vld, locked;

  int total = 0, bad = 0;
  bit chk_en = 0, gaps = 0;
  int nslot = 1;
  int skew [3];
  logic [9:0] dl [3][8];

  always #2.5 clk = ~clk;

  vlink_destuff #(.DEPTH(4)) i_vlink_destuff (
    .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .ratio(ratio),
    .ch_b(ch_b), .ch_g(ch_g), .ch_r(ch_r), .red(red), .grn(grn), .blu(blu),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_vld(pix_vld), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit special(input logic [9:0] c);
    return c == FILL || c == 10'h354 || c == 10'h0AB || c == 10'h154 || c == 10'h2AB;
  endfunction

  function automatic logic [9:0] ctl(input logic [1:0] vh);
    case (vh)
      2'b00: return 10'b1101010100;
      2'b01: return 10'b0010101011;
      2'b10: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] enc(input logic [7:0] d, input logic use_xor, input logic inv);
    logic [7:0] qm;
    qm[0] = d[0];
    for (int i = 1; i < 8; i++) qm[i] = use_xor ? (qm[i-1] ^ d[i]) : ~(qm[i-1] ^ d[i]);
    return {inv, use_xor, inv ? ~qm : qm};
  endfunction

  function automatic logic [9:0] enc_rand(input logic [7:0] d);
    logic [9:0] c;
    do c = enc(d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))); while (special(c));
    return c;
  endfunction

  task automatic slot(input logic [9:0] b, input logic [9:0] g, input logic [9:0] r);
    logic [9:0] cv [3];
    cv[0] = b; cv[1] = g; cv[2] = r;
    if (gaps && $urandom_range(0, 4) == 0) begin
      lane_en = 1'b0;
      @(posedge clk); #1;
    end
    for (int l = 0; l < 3; l++) begin
      for (int k = 7; k > 0; k--) dl[l][k] = dl[l][k-1];
      dl[l][0] = cv[l];
    end
    ch_b = dl[0][skew[0]];
    ch_g = dl[1][skew[1]];
    ch_r = dl[2][skew[2]];
    lane_en = 1'b1;
    @(posedge clk); #1;
    lane_en = 1'b0;
  endtask

  task automatic pixel(input logic [9:0] b, input logic [9:0] g, input logic [9:0] r);
    slot(b, g, r);
    for (int s = 1; s < nslot; s++) slot(FILL, FILL, FILL);
  endtask

  task automatic line(input int ln, input bit inject, input bit want);
    logic [7:0] gv, rv;
    gv = ln[7:0];
    for (int p = 0; p < BLANK; p++) begin
      pixel(ctl({gv[0], gv[1]}), ctl(2'b00), ctl(2'b00));
      if (p == 11) chk_en = want;
    end
    for (int col = 0; col < ACTIVE; col++) begin
      rv = col[7:0];
      pixel(enc_rand(rv ^ gv ^ 8'h3C), enc_rand(gv),
            (inject && col == 12) ? FILL : enc_rand(rv));
    end
  endtask

  task automatic set_skew(input int b, input int g, input int r);
    skew[0] = b; skew[1] = g; skew[2] = r;
  endtask

  task automatic run_mode(input logic [1:0] rt, input bit with_gaps);
    chk_en = 0;
    rst_n = 1'b0;
    lane_en = 1'b0;
    ratio = rt;
    gaps = with_gaps;
    nslot = (rt == 2'd0) ? 1 : (rt == 2'd1) ? 2 : 4;
    for (int l = 0; l < 3; l++) for (int k = 0; k < 8; k++) dl[l][k] = '0;
    set_skew(1, 3, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({red, grn, blu, hsync, vsync, de, pix_vld, locked} == '0, "R1 reset state",
        int'({hsync, vsync, de, pix_vld, locked}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    line(0, 0, 0);
    line(1, 0, 0);
    chk(locked == 1'b1, "R5 lock after first blanking", int'(locked), 1);
    line(2, 0, 1);
    line(3, 0, 1);
    line(4, 0, 1);
    chk_en = 0;
    set_skew(3, 0, 2);
    line(5, 0, 0);
    line(6, 0, 1);
    line(7, 0, 1);
    chk(locked == 1'b1, "R6 relocked after skew change", int'(locked), 1);
    chk_en = 0;
    line(8, 1, 0);
    chk(locked == 1'b0, "R7 filler in data slot drops lock", int'(locked), 0);
    line(9, 0, 0);
    chk(locked == 1'b1, "R7 relock on next blanking", int'(locked), 1);
    line(10, 0, 1);
    line(11, 0, 1);
    chk_en = 0;
    set_skew(0, 0, 6);
    line(12, 0, 0);
    chk(locked == 1'b0, "R8 excessive skew drops lock", int'(locked), 0);
    set_skew(2, 1, 0);
    line(13, 0, 0);
    line(14, 0, 1);
    line(15, 0, 1);
    chk(locked == 1'b1, "R8 relock after skew restored", int'(locked), 1);
    chk_en = 0;
  endtask

  // output monitor
  initial begin
    bit prev_en = 0, chk_d = 0, prev_de = 0, have_last = 0;
    logic [7:0] prev_r = '0, cur_g = '0, last_g = '0, nxt;
    forever begin
      @(negedge clk);
      if (chk_en) begin
        if (!chk_d) begin
          prev_de = 0;
          have_last = 0;
        end
        if (!prev_en) chk(!pix_vld, "R9 no strobe after idle", int'(pix_vld), 0);
        if (pix_vld) begin
          if (de) begin
            if (!prev_de) begin
              chk(red == 8'd0, "R2 line starts at first pixel", red, 0);
              if (have_last) chk(grn == last_g + 8'd1, "R3 line number", grn, last_g + 8'd1);
              cur_g = grn;
            end else begin
              chk(red == prev_r + 8'd1, "R2 pixel order", red, prev_r + 8'd1);
            end
            chk(grn == cur_g, "R3 green component", grn, cur_g);
            chk(blu == (red ^ grn ^ 8'h3C), "R3 blue component", blu, red ^ grn ^ 8'h3C);
            prev_r = red;
          end else begin
            if (prev_de) begin
              chk(prev_r == 8'(ACTIVE - 1), "R2 pixels per line", prev_r, ACTIVE - 1);
              last_g = cur_g;
              have_last = 1;
            end
            chk({red, grn, blu} == '0, "R4 blank colour", int'({red, grn, blu}), 0);
            if (have_last) begin
              nxt = last_g + 8'd1;
              chk(hsync == nxt[1], "R4 hsync code", int'(hsync), int'(nxt[1]));
              chk(vsync == nxt[0], "R4 vsync code", int'(vsync), int'(nxt[0]));
            end
          end
          prev_de = de;
        end
      end
      chk_d = chk_en;
      prev_en = lane_en;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired (all R)", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2718);
    run_mode(2'd0, 0);
    run_mode(2'd1, 1);
    run_mode(2'd2, 1);
    run_mode(2'd3, 0);
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule